// File: doc/BRIEF.md
# Debug Halt Peripheral Freeze Register

This block is a one-word control register on the debug side of the chip. It tells selected timer counters to stop counting while a debugger holds the processor core halted. A debugger writes one stop bit per freezable timer. The block combines each stop bit with the core-halted indication and drives a registered clock-enable for that timer. The enable is low only while the core is halted and that timer's stop bit is set.

The register is on the power-on reset and not the system reset. A system reset therefore leaves the debugger's settings in place, and the debugger can program the register while the rest of the system is held in reset. The bus side accepts only full 32-bit accesses at one fixed word address. A narrower access at that address gets an error response. Any other address is ignored.

Top module: `dbg_halt_freeze_reg`

## Requirements
- R1: Asserting `por_n` low clears every stop bit asynchronously. After power-on, a word read returns 0x0000_0000.
- R2: Holding `sys_rst_n` low changes no stop bit. A word read after the system reset returns the value that was written before it.
- R3: A word write at the register address takes effect while `sys_rst_n` is low, and it gets a normal response.
- R4: A request at address 0xE004_200C with size code 2'b10 (word; 2'b00 byte, 2'b01 halfword, 2'b11 invalid) gets `rsp_valid` high in the following cycle with `rsp_err` low. A write stores wdata bit 0 (timer 1), bit 16 (timer 9) and bit 18 (timer 11). A read returns those bits at the same positions. A write response returns zero data.
- R5: Every bit other than 0, 16 and 18 reads as zero, and writing to those bits has no effect.
- R6: A request at the register address with any size code other than 2'b10 gets `rsp_valid` and `rsp_err` high in the following cycle with zero read data, and it changes no stored bit.
- R7: A request at any other address gets no response: `rsp_valid` and `rsp_err` stay low and `rsp_rdata` stays zero.
- R8: Outside system reset, on each clock edge `tmr_clk_en[i]` takes the value NOT(`core_halted` AND stop bit i), using the values present at that edge. Index 0 is timer 1, index 1 is timer 9 and index 2 is timer 11.
- R9: At each clock edge where `sys_rst_n` is low, all `tmr_clk_en` bits are set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the debug bus and the timers |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous; resets only the enable stage |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_size | input | 2 | Access size code: 00 byte, 01 halfword, 10 word, 11 invalid |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for a claimed request, one cycle after it |
| rsp_err | output | 1 | Error flag for a non-word access |
| rsp_rdata | output | 32 | Read data; zero unless the access is a word read |
| core_halted | input | 1 | High while the core is halted by the debugger |
| tmr_clk_en | output | 3 | Per-timer clock-enable, registered |

## Verification
A corrupted stop bit appears at the ports in two ways. A word read returns it in the next cycle. With the core halted, the timer's enable drops one edge after the fault. Because of this, the bench keeps `core_halted` random while it reads and writes. A stop bit lost to a system reset, or written by a narrow access, shows up in the next read-back. The comparison at the response stage flags any reserved bit that reads as one, and a missing or misplaced error flag, in the cycle after the request.

// File: rtl/dhf_pkg.sv
// Shared types and constants for the debug halt freeze register.
// Assumes byte addressing with a two-bit access size code.
package dhf_pkg;

    // Width of one entry in the packed stop-bit position list
    localparam int POS_W = 5;

    // Access size codes carried on req_size
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;

endpackage

// File: rtl/dhf_bus_slave.sv
// Bus slave for the freeze register: decodes the single word address,
// refuses narrow accesses with an error and registers the response.
// Assumes one request per cycle and no back-pressure; the response
// registers sit on the power-on domain so they work during system reset.
module dhf_bus_slave
    import dhf_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              DATA_W   = 32,
    parameter logic [ADDR_W-1:0] REG_ADDR = 32'hE004_200C
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wr_stb,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic hit;
    logic full_word;

    // Address and size decode for the current request
    always_comb begin
        hit       = req_valid && (req_addr == REG_ADDR);
        full_word = (req_size == SZ_WORD);
        wr_stb    = hit && full_word && req_write;
    end

    // Response stage: one cycle after a claimed request
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= hit;
            rsp_err   <= hit && !full_word;
            rsp_rdata <= (hit && full_word && !req_write) ? rd_word : '0;
        end
    end

endmodule

// File: rtl/dhf_stop_store.sv
// Storage for the per-timer stop bits. Only the implemented bits exist,
// so reserved positions read as zero and ignore writes.
// Assumes STOP_POS holds NUM_TMR distinct positions below DATA_W.
module dhf_stop_store
    import dhf_pkg::*;
#(
    parameter int                      DATA_W   = 32,
    parameter int                      NUM_TMR  = 3,
    parameter logic [NUM_TMR*POS_W-1:0] STOP_POS = {5'd18, 5'd16, 5'd0}
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               wr_stb,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_TMR-1:0] stop_q,
    output logic [DATA_W-1:0]  rd_word
);

    // Stop bits: cleared only by power-on reset, loaded on a word write
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            stop_q <= '0;
        end else if (wr_stb) begin
            for (int i = 0; i < NUM_TMR; i++) begin
                stop_q[i] <= wdata[STOP_POS[i*POS_W +: POS_W]];
            end
        end
    end

    // Place each stop bit back at its word position for reads
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            rd_word[STOP_POS[i*POS_W +: POS_W]] = stop_q[i];
        end
    end

endmodule

// File: rtl/dhf_clk_gate.sv
// One timer's clock-enable: low while the core is halted and the stop
// bit is set. Registered so the enable only changes at a clock edge.
// Assumes the timer runs on the same clock as this block.
module dhf_clk_gate (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic halted,
    input  logic stop,
    output logic clk_en
);

    // Registered enable; system reset lets the timer clock run
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            clk_en <= 1'b1;
        end else begin
            clk_en <= !(halted && stop);
        end
    end

endmodule

// File: rtl/dbg_halt_freeze_reg.sv
// Top of the debug halt freeze register. The bus slave and the stop bits
// sit in the power-on domain (asynchronous por_n). The per-timer enables
// sit in the system domain (synchronous sys_rst_n).
// Assumes the bus and the timers share clk.
module dbg_halt_freeze_reg
    import dhf_pkg::*;
#(
    parameter int                      ADDR_W   = 32,
    parameter int                      DATA_W   = 32,
    parameter int                      NUM_TMR  = 3,
    parameter logic [ADDR_W-1:0]       REG_ADDR = 32'hE004_200C,
    parameter logic [NUM_TMR*POS_W-1:0] STOP_POS = {5'd18, 5'd16, 5'd0}
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               sys_rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata,
    input  logic               core_halted,
    output logic [NUM_TMR-1:0] tmr_clk_en
);

    logic               wr_stb;
    logic [DATA_W-1:0]  rd_word;
    logic [NUM_TMR-1:0] stop_q;

    dhf_bus_slave #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .REG_ADDR(REG_ADDR)
    ) u_bus (
        .clk      (clk),
        .por_n    (por_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_size (req_size),
        .rd_word  (rd_word),
        .wr_stb   (wr_stb),
        .rsp_valid(rsp_valid),
        .rsp_err  (rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    dhf_stop_store #(
        .DATA_W  (DATA_W),
        .NUM_TMR (NUM_TMR),
        .STOP_POS(STOP_POS)
    ) u_store (
        .clk    (clk),
        .por_n  (por_n),
        .wr_stb (wr_stb),
        .wdata  (req_wdata),
        .stop_q (stop_q),
        .rd_word(rd_word)
    );

    // One gating stage per freezable timer
    for (genvar g = 0; g < NUM_TMR; g++) begin : g_gate
        dhf_clk_gate u_gate (
            .clk      (clk),
            .sys_rst_n(sys_rst_n),
            .halted   (core_halted),
            .stop     (stop_q[g]),
            .clk_en   (tmr_clk_en[g])
        );
    end

endmodule

// File: rtl/dhf_chk.sv
// Checker for the debug halt freeze register, bound to the top module.
// Observes ports and the stored stop bits.
module dhf_chk
    import dhf_pkg::*;
#(
    parameter int                      ADDR_W   = 32,
    parameter int                      DATA_W   = 32,
    parameter int                      NUM_TMR  = 3,
    parameter logic [ADDR_W-1:0]       REG_ADDR = 32'hE004_200C,
    parameter logic [NUM_TMR*POS_W-1:0] STOP_POS = {5'd18, 5'd16, 5'd0}
) (
    input logic               clk,
    input logic               por_n,
    input logic               sys_rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [1:0]         req_size,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic               core_halted,
    input logic [NUM_TMR-1:0] tmr_clk_en,
    input logic [NUM_TMR-1:0] stop_q
);

    function automatic logic [DATA_W-1:0] impl_mask();
        logic [DATA_W-1:0] m = '0;
        for (int i = 0; i < NUM_TMR; i++) m[STOP_POS[i*POS_W +: POS_W]] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] IMPL_MASK = impl_mask();

    logic hit_req;
    assign hit_req = req_valid && (req_addr == REG_ADDR);

    // R2
    sysrst_keeps_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && !(req_valid && req_write)) |=> $stable(stop_q));

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rsp_rdata & ~IMPL_MASK) == '0);

    // R6
    narrow_err_chk: assert property (@(posedge clk) disable iff (!por_n)
        (hit_req && req_size != SZ_WORD) |=> (rsp_valid && rsp_err && rsp_rdata == '0));

    // R6
    narrow_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (hit_req && req_size != SZ_WORD) |=> $stable(stop_q));

    // R7
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        !hit_req |=> (!rsp_valid && !rsp_err && rsp_rdata == '0));

    // R8
    gate_follow_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        1'b1 |=> tmr_clk_en == ~({NUM_TMR{$past(core_halted)}} & $past(stop_q)));

    // R9
    sysrst_enable_chk: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> &tmr_clk_en);

endmodule

bind dbg_halt_freeze_reg dhf_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_TMR (NUM_TMR),
    .REG_ADDR(REG_ADDR),
    .STOP_POS(STOP_POS)
) u_chk (.*);

// File: tb/dbg_halt_freeze_reg_bench.sv
// Bench for the debug halt freeze register: directed corner cases, then
// seeded random traffic, all checked against a bench-side model.
module dbg_halt_freeze_reg_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RADDR      = 32'hE004_200C;
    localparam logic [31:0] MASK       = 32'h0005_0001;

    logic        clk = 1'b0;
    logic        por_n, sys_rst_n;
    logic        req_valid, req_write;
    logic [31:0] req_addr, req_wdata;
    logic [1:0]  req_size;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        core_halted;
    logic [2:0]  tmr_clk_en;

    int checks = 0;
    int errors = 0;

    logic [2:0] m_stop;
    logic [2:0] m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_halt_freeze_reg u_dbg_halt_freeze_reg (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .core_halted(core_halted), .tmr_clk_en(tmr_clk_en)
    );

    function automatic logic [31:0] word_of(input logic [2:0] s);
        return {13'd0, s[2], 1'b0, s[1], 15'd0, s[0]};
    endfunction

    function automatic logic [2:0] stop_of(input logic [31:0] w);
        return {w[18], w[16], w[0]};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One bus cycle: drive at negedge, model at posedge, compare just after
    task automatic step(input logic v, input logic w, input logic [31:0] a,
                        input logic [1:0] sz, input logic [31:0] d,
                        input logic h, input logic srn);
        logic hit, word;
        logic e_v, e_e;
        logic [31:0] e_d;
        string rtag;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_size = sz;
        req_wdata = d; core_halted = h; sys_rst_n = srn;
        @(posedge clk);
        hit  = v && (a == RADDR);
        word = (sz == 2'b10);
        m_en = !srn ? 3'b111 : ~({3{h}} & m_stop);
        e_v  = hit;
        e_e  = hit && !word;
        e_d  = (hit && word && !w) ? word_of(m_stop) : 32'd0;
        if (hit && word && w) m_stop = stop_of(d);
        rtag = !hit ? "R7" : (!word ? "R6" : (!srn ? "R3" : "R4"));
        #1;
        chk(rsp_valid == e_v && rsp_err == e_e, rtag, {30'd0, rsp_valid, rsp_err}, {30'd0, e_v, e_e});
        chk(rsp_rdata == e_d, rtag, rsp_rdata, e_d);
        if (hit && word && !w) chk((rsp_rdata & ~MASK) == 0, "R5", rsp_rdata & ~MASK, 32'd0);
        chk(tmr_clk_en == m_en, srn ? "R8" : "R9", {29'd0, tmr_clk_en}, {29'd0, m_en});
    endtask

    task automatic idle(input logic h, input logic srn);
        step(1'b0, 1'b0, 32'd0, 2'b10, 32'd0, h, srn);
    endtask

    task automatic rd_expect(input logic srn, input string tag, input logic [31:0] exp);
        step(1'b1, 1'b0, RADDR, 2'b10, 32'd0, 1'b0, srn);
        chk(rsp_rdata == exp, tag, rsp_rdata, exp);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        por_n = 1'b0; sys_rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_size = 2'b10; req_wdata = '0; core_halted = 1'b0;
        m_stop = 3'b000; m_en = 3'b111;
        repeat (3) @(posedge clk);
        @(negedge clk); por_n = 1'b1;

        // R1: power-on value reads as zero, enables held on in reset (R9)
        idle(1'b1, 1'b0);
        rd_expect(1'b0, "R1", 32'd0);

        // R3 and R5: write all ones during system reset, reserved bits drop
        step(1'b1, 1'b1, RADDR, 2'b10, 32'hFFFF_FFFF, 1'b1, 1'b0);
        rd_expect(1'b0, "R3", 32'h0005_0001);

        // R8: leave system reset, halt the core, all timers freeze
        idle(1'b1, 1'b1);
        idle(1'b1, 1'b1);
        idle(1'b0, 1'b1);

        // R4: single bit patterns
        step(1'b1, 1'b1, RADDR, 2'b10, 32'h0001_0000, 1'b1, 1'b1);
        idle(1'b1, 1'b1);
        rd_expect(1'b1, "R4", 32'h0001_0000);

        // R2: system reset pulse keeps the contents
        step(1'b1, 1'b1, RADDR, 2'b10, 32'h0004_0001, 1'b0, 1'b1);
        repeat (4) idle(1'b1, 1'b0);
        rd_expect(1'b1, "R2", 32'h0004_0001);

        // R6: byte and halfword writes are refused and change nothing
        step(1'b1, 1'b1, RADDR, 2'b00, 32'h0000_0000, 1'b1, 1'b1);
        step(1'b1, 1'b1, RADDR, 2'b01, 32'h0000_0000, 1'b1, 1'b1);
        step(1'b1, 1'b0, RADDR, 2'b11, 32'h0, 1'b1, 1'b1);
        rd_expect(1'b1, "R6", 32'h0004_0001);

        // R7: nearby addresses are not claimed
        step(1'b1, 1'b1, RADDR + 32'd4, 2'b10, 32'd0, 1'b1, 1'b1);
        step(1'b1, 1'b0, RADDR - 32'd4, 2'b10, 32'd0, 1'b1, 1'b1);
        rd_expect(1'b1, "R7", 32'h0004_0001);

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic v, w, h, srn;
            logic [31:0] a, d;
            logic [1:0] sz;
            v   = ($urandom % 8) != 0;
            w   = $urandom % 2;
            a   = ($urandom % 4 != 0) ? RADDR : $urandom;
            sz  = ($urandom % 4 != 0) ? 2'b10 : 2'($urandom);
            d   = $urandom;
            h   = $urandom % 2;
            srn = ($urandom % 16) != 0;
            step(v, w, a, sz, d, h, srn);
        end

        summary();
    end

endmodule